// File: doc/BRIEF.md
# SDRAM Initialization and Refresh Sequencer

This block owns the control lines of a four-bank SDRAM rank from reset until normal traffic starts, and afterwards it keeps the rank refreshed. After reset it holds the bus in NOP for a power-up pause. It then closes every bank and issues a fixed run of auto-refresh commands. Last, it writes the mode register and raises a completion flag. All wait times are given in nanoseconds and turned into clock cycles, rounded up.

In normal operation an interval counter adds one refresh credit per refresh period. The credit count is capped at a postpone limit. The sequencer asks a read/write command engine for the bus with `ref_req`. The engine answers with `ref_gnt` once all banks are closed, and holds it until `ref_req` drops. If the credit count has reached its cap, the next grant produces two refreshes in a row. A self-refresh request takes priority over pending credits. Self-refresh is entered with a refresh command while CKE goes low. On exit, CKE rises, two edges pass before the exit completes, and then a row-cycle settle time is waited out.

Top module: `sdr_init_refresh_seq`

## Requirements
- R1: While reset is held and for the power-up pause afterwards, the bus carries only NOP (CS_n low; RAS_n, CAS_n and WE_n high) with CKE high. The precharge-all command appears exactly PWR cycles after reset release, where PWR = ceil(pause / clock period). Precharge-all is encoded as CS_n=0, RAS_n=0, CAS_n=1, WE_n=0 with addr[10]=1.
- R2: Initialization issues, in this order only: one precharge-all; then INIT_REFS auto-refresh commands (CS_n=0, RAS_n=0, CAS_n=0, WE_n=1); then one mode-register write (all four strobes low) carrying MODE_WORD on addr with ba=0.
- R3: init_done rises exactly TMRD_CYC cycles after the mode-register write and then stays high until reset.
- R4: Every spacing is the wait time divided by the clock period, rounded up. Precharge-all to the first refresh is ceil(tRP). Each initialization refresh to the next command is ceil(tRC).
- R5: After init_done, one refresh credit is added every REFI = ceil(interval / period) cycles. ref_req first rises REFI cycles after init_done. Over any stretch, the refreshes issued equal the credits earned, provided the cap is not hit.
- R6: After initialization, no command other than NOP is driven unless ref_gnt was high on the previous cycle. With credit pending, a refresh appears one cycle after ref_gnt is raised.
- R7: Credits saturate at POSTPONE_MAX. A grant given at saturation yields two refreshes exactly ceil(tRC) cycles apart. A full backlog drains with exactly POSTPONE_MAX refreshes.
- R8: ref_req stays high while a refresh is in progress. Successive refreshes are at least ceil(tRC) cycles apart.
- R9: With sr_req high, a grant issues a refresh command in the same cycle that CKE goes low. This takes priority over pending credit.
- R10: CKE stays low while sr_req stays high, and returns high one cycle after sr_req drops. ref_req stays low and no command is issued until exactly ceil(tRC)+3 cycles after the cycle in which CKE is seen high: two edges to start the exit, the settle time, and one cycle to re-enter idle.
- R11: Self-refresh discards pending credit and restarts the interval. After exit, ref_req rises exactly ceil(tRC)+2+REFI cycles after the cycle in which CKE is seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Engine has closed all banks and yields the bus |
| sr_req | input | 1 | Level request to stay in self-refresh |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address; bit 10 selects all banks on precharge, mode word on register write |
| ba | output | BA_W | Bank select, always zero |
| cke | output | 1 | Clock enable |
| ref_req | output | 1 | Request for the bus to refresh or enter self-refresh |
| init_done | output | 1 | Initialization complete |

## Verification
Every command leaves a register, so a decision made at clock edge k is visible on the pins in the half cycle after edge k. The bench counts edges from reset release and samples on falling edges.

Using that count, the expected timings are:
- the precharge-all is due at edge PWR;
- each later initialization command is due a fixed rounded-up spacing after the one before;
- init_done is due TMRD_CYC edges after the mode write;
- ref_req is due REFI edges after init_done;
- a granted refresh is due one edge after the grant is driven.

The self-refresh exit is timed from the first sample that shows CKE high: the next command is expected ceil(tRC)+3 edges later, and a fresh ref_req ceil(tRC)+2+REFI edges later. Each check compares the exact sample index against these counts, rather than waiting for an event.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE_ALL,
        CMD_AREF,
        CMD_MODE
    } cmd_e;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_PRE,
        ST_IREF,
        ST_MODE,
        ST_IDLE,
        ST_REF,
        ST_SELF,
        ST_SRX,
        ST_SRW
    } st_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    function automatic int ns2cyc(input int ns, input int ps);
        longint num;
        num = longint'(ns) * 1000;
        return int'((num + longint'(ps) - 1) / longint'(ps));
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_delay_timer.sv
module sdr_delay_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R4: an unloaded timer moves down by exactly one per cycle
    p_timer_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdr_refresh_credit.sv
module sdr_refresh_credit #(
    parameter int INTERVAL = 1560,
    parameter int LIMIT    = 8,
    parameter int PW       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clear,
    input  logic          take,
    output logic [PW-1:0] pending,
    output logic          full
);
    localparam int IW = $clog2(INTERVAL + 1);

    logic [IW-1:0] intv_q;
    logic          tick;
    logic [PW-1:0] pend_q;
    logic [PW-1:0] after_take;

    assign tick = run && (intv_q == IW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst || clear || !run || tick)
            intv_q <= '0;
        else
            intv_q <= intv_q + 1'b1;
    end

    always_comb begin
        after_take = pend_q - (take ? PW'(1) : PW'(0));
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            pend_q <= '0;
        else if (tick && after_take != PW'(LIMIT))
            pend_q <= after_take + 1'b1;
        else
            pend_q <= after_take;
    end

    assign pending = pend_q;
    assign full    = (pend_q == PW'(LIMIT));

    // R7: credit never passes the postpone limit
    p_credit_cap_r7: assert property (@(posedge clk) disable iff (rst)
        pend_q <= PW'(LIMIT));

    // R5: a refresh is only charged against existing credit
    p_take_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        take |-> (pend_q != '0));

endmodule

// File: rtl/sdr_cmd_encode.sv
module sdr_cmd_encode
    import sdr_seq_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input  cmd_e              cmd,
    output pins_t             pins,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = '0;
        case (cmd)
            CMD_PRE_ALL: begin
                pins     = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
                addr[10] = 1'b1;
            end
            CMD_AREF:  pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_MODE: begin
                pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
                addr = MODE_WORD;
            end
            default:   pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    end
endmodule

// File: rtl/sdr_init_refresh_seq.sv
module sdr_init_refresh_seq
    import sdr_seq_pkg::*;
#(
    parameter int                CLK_PS       = 10000,
    parameter int                PWRUP_NS     = 100000,
    parameter int                TRP_NS       = 20,
    parameter int                TRC_NS       = 70,
    parameter int                REFI_NS      = 15600,
    parameter int                TMRD_CYC     = 2,
    parameter int                INIT_REFS    = 8,
    parameter int                POSTPONE_MAX = 8,
    parameter int                ADDR_W       = 12,
    parameter int                BA_W         = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD    = 'h022
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_gnt,
    input  logic              sr_req,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              cke,
    output logic              ref_req,
    output logic              init_done
);
    localparam int PWR_C  = ns2cyc(PWRUP_NS, CLK_PS);
    localparam int TRP_C  = ns2cyc(TRP_NS, CLK_PS);
    localparam int TRC_C  = ns2cyc(TRC_NS, CLK_PS);
    localparam int REFI_C = ns2cyc(REFI_NS, CLK_PS);
    localparam int TMAX   = imax(imax(PWR_C, TRC_C), imax(TRP_C, TMRD_CYC));
    localparam int TW     = $clog2(TMAX + 1);
    localparam int ICW    = $clog2(INIT_REFS + 1);
    localparam int PW     = $clog2(POSTPONE_MAX + 1);

    st_e            st_q, st_n;
    cmd_e           cmd_q, cmd_n;
    logic           cke_q, cke_n;
    logic           done_q, done_n;
    logic           extra_q, extra_n;
    logic [ICW-1:0] icnt_q, icnt_n;
    logic           ld;
    logic [TW-1:0]  ldv;
    logic           expired;
    logic           take;
    logic [PW-1:0]  pending;
    logic           full;
    logic           run;
    logic           clear;
    pins_t          pins;

    sdr_delay_timer #(.W(TW), .RST_VAL(PWR_C - 1)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ldv),
        .expired  (expired)
    );

    assign run   = done_q && (st_q == ST_IDLE || st_q == ST_REF);
    assign clear = (st_q == ST_SELF) || (st_q == ST_SRX) || (st_q == ST_SRW);

    sdr_refresh_credit #(.INTERVAL(REFI_C), .LIMIT(POSTPONE_MAX), .PW(PW)) u_credit (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .clear   (clear),
        .take    (take),
        .pending (pending),
        .full    (full)
    );

    sdr_cmd_encode #(.ADDR_W(ADDR_W), .MODE_WORD(MODE_WORD)) u_enc (
        .cmd  (cmd_q),
        .pins (pins),
        .addr (addr)
    );

    always_comb begin
        st_n    = st_q;
        cmd_n   = CMD_NOP;
        cke_n   = cke_q;
        done_n  = done_q;
        extra_n = extra_q;
        icnt_n  = icnt_q;
        ld      = 1'b0;
        ldv     = '0;
        take    = 1'b0;
        case (st_q)
            ST_PAUSE: if (expired) begin
                cmd_n = CMD_PRE_ALL;
                ld    = 1'b1;
                ldv   = TW'(TRP_C - 1);
                st_n  = ST_PRE;
            end
            ST_PRE: if (expired) begin
                cmd_n  = CMD_AREF;
                ld     = 1'b1;
                ldv    = TW'(TRC_C - 1);
                icnt_n = ICW'(1);
                st_n   = ST_IREF;
            end
            ST_IREF: if (expired) begin
                ld = 1'b1;
                if (icnt_q == ICW'(INIT_REFS)) begin
                    cmd_n = CMD_MODE;
                    ldv   = TW'(TMRD_CYC - 1);
                    st_n  = ST_MODE;
                end else begin
                    cmd_n  = CMD_AREF;
                    ldv    = TW'(TRC_C - 1);
                    icnt_n = icnt_q + 1'b1;
                end
            end
            ST_MODE: if (expired) begin
                done_n = 1'b1;
                st_n   = ST_IDLE;
            end
            ST_IDLE: if (ref_gnt) begin
                if (sr_req) begin
                    cmd_n = CMD_AREF;
                    cke_n = 1'b0;
                    st_n  = ST_SELF;
                end else if (pending != '0) begin
                    cmd_n   = CMD_AREF;
                    take    = 1'b1;
                    ld      = 1'b1;
                    ldv     = TW'(TRC_C - 1);
                    extra_n = full;
                    st_n    = ST_REF;
                end
            end
            ST_REF: if (expired) begin
                if (extra_q) begin
                    cmd_n   = CMD_AREF;
                    take    = 1'b1;
                    ld      = 1'b1;
                    ldv     = TW'(TRC_C - 1);
                    extra_n = 1'b0;
                end else begin
                    st_n = ST_IDLE;
                end
            end
            ST_SELF: if (!sr_req) begin
                cke_n = 1'b1;
                ld    = 1'b1;
                ldv   = TW'(1);
                st_n  = ST_SRX;
            end
            ST_SRX: if (expired) begin
                ld   = 1'b1;
                ldv  = TW'(TRC_C - 1);
                st_n = ST_SRW;
            end
            ST_SRW: if (expired) st_n = ST_IDLE;
            default: st_n = ST_PAUSE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_PAUSE;
            cmd_q   <= CMD_NOP;
            cke_q   <= 1'b1;
            done_q  <= 1'b0;
            extra_q <= 1'b0;
            icnt_q  <= '0;
        end else begin
            st_q    <= st_n;
            cmd_q   <= cmd_n;
            cke_q   <= cke_n;
            done_q  <= done_n;
            extra_q <= extra_n;
            icnt_q  <= icnt_n;
        end
    end

    assign cs_n      = pins.cs_n;
    assign ras_n     = pins.ras_n;
    assign cas_n     = pins.cas_n;
    assign we_n      = pins.we_n;
    assign ba        = '0;
    assign cke       = cke_q;
    assign init_done = done_q;
    assign ref_req   = done_q && (st_q == ST_REF ||
                       (st_q == ST_IDLE && (pending != '0 || sr_req)));

    // R1: the pause carries nothing but NOP
    p_pause_nop_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PAUSE) |-> (!cs_n && ras_n && cas_n && we_n));

    // R3: completion flag is sticky
    p_done_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R6: post-init commands only follow a grant
    p_grant_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (init_done && !cs_n && !ras_n && !cas_n && we_n) |-> $past(ref_gnt));

    // R9: CKE only falls together with a refresh command
    p_cke_fall_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> (!cs_n && !ras_n && !cas_n && we_n));

    // R10: clock enable held low in self-refresh
    p_self_cke_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SELF) |-> !cke);

    // R10: exit window is quiet
    p_exit_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SRX || st_q == ST_SRW) |-> (ras_n && cas_n && we_n && !ref_req));

endmodule

// File: tb/sdr_init_refresh_seq_test.sv
`timescale 1ns/1ps
module sdr_init_refresh_seq_test;
    localparam int CLK_PS = 10000;
    localparam int PWRUP  = 1500;
    localparam int TRPNS  = 15;
    localparam int TRCNS  = 65;
    localparam int REFINS = 1000;
    localparam int TMRD   = 2;
    localparam int NREF   = 8;
    localparam int CAP    = 8;
    localparam logic [11:0] MODE = 12'h032;

    function automatic int cdiv(input int ns);
        return (ns * 1000 + CLK_PS - 1) / CLK_PS;
    endfunction

    localparam int PWR  = cdiv(PWRUP);
    localparam int TRP  = cdiv(TRPNS);
    localparam int TRC  = cdiv(TRCNS);
    localparam int REFI = cdiv(REFINS);

    logic clk = 1'b0;
    logic rst;
    logic ref_gnt;
    logic sr_req;
    logic cs_n, ras_n, cas_n, we_n, cke, ref_req, init_done;
    logic [11:0] addr;
    logic [1:0]  ba;

    always #5 clk = ~clk;

    sdr_init_refresh_seq #(
        .CLK_PS(CLK_PS), .PWRUP_NS(PWRUP), .TRP_NS(TRPNS), .TRC_NS(TRCNS),
        .REFI_NS(REFINS), .TMRD_CYC(TMRD), .INIT_REFS(NREF), .POSTPONE_MAX(CAP),
        .ADDR_W(12), .BA_W(2), .MODE_WORD(MODE)
    ) uut (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .sr_req(sr_req),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba), .cke(cke), .ref_req(ref_req), .init_done(init_done)
    );

    int checks = 0;
    int fails  = 0;
    int t      = 0;
    bit fin    = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // 0 NOP, 1 precharge, 2 refresh, 3 mode, 9 anything else
    function automatic int dec();
        case ({cs_n, ras_n, cas_n, we_n})
            4'b0111: return 0;
            4'b0010: return 1;
            4'b0001: return 2;
            4'b0000: return 3;
            default: return 9;
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
        t = t + 1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #2000000;
        if (!fin) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        int ct[10];
        int cc[10];
        int nc, tdone, ti, tr, tg, nref, lastref, ticks, refs, x, tc, bad, c;
        int rt[16];
        logic [11:0] pre_addr, mode_addr;
        logic [1:0]  mode_ba;
        bit cke_bad;
        void'($urandom(32'h5D1A7));
        rst = 1'b1; ref_gnt = 1'b0; sr_req = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dec() == 0 && cke && !init_done && !ref_req, "R1 reset state",
            {cs_n, ras_n, cas_n, we_n}, 7);
        rst = 1'b0;
        t = 0;

        // Initialization
        nc = 0; tdone = -1; cke_bad = 0; bad = 0;
        pre_addr = '0; mode_addr = '0; mode_ba = '0;
        while (tdone < 0 && t < PWR + 200) begin
            step();
            c = dec();
            if (!cke) cke_bad = 1;
            if (c != 0) begin
                if (nc < 10) begin
                    ct[nc] = t; cc[nc] = c;
                    if (nc == 0) pre_addr = addr;
                    if (nc == 9) begin mode_addr = addr; mode_ba = ba; end
                end
                nc++;
            end
            if (init_done) tdone = t;
        end
        chk(nc == 10, "R2 init command count", nc, 10);
        chk(cc[0] == 1 && ct[0] == PWR && pre_addr[10], "R1 precharge-all time", ct[0], PWR);
        chk(!cke_bad, "R1 cke high during init", cke_bad, 0);
        chk(ct[1] - ct[0] == TRP, "R4 precharge to refresh", ct[1] - ct[0], TRP);
        for (int i = 1; i <= 8; i++) if (cc[i] != 2) bad++;
        chk(bad == 0, "R2 eight refreshes in order", bad, 0);
        bad = 0;
        for (int i = 2; i <= 9; i++) if (ct[i] - ct[i-1] != TRC) bad++;
        chk(bad == 0, "R4 refresh spacing", bad, 0);
        chk(cc[9] == 3 && mode_addr == MODE && mode_ba == 0, "R2 mode write",
            int'(mode_addr), int'(MODE));
        chk(tdone == ct[9] + TMRD, "R3 init_done timing", tdone, ct[9] + TMRD);

        // Refresh interval and postponement
        ti = tdone; tr = -1; bad = 0;
        while (tr < 0 && t < ti + REFI + 10) begin
            step();
            if (dec() != 0) bad++;
            if (ref_req) tr = t;
        end
        chk(tr - ti == REFI, "R5 first ref_req", tr - ti, REFI);
        while (t < ti + 10 * REFI + 5) begin
            step();
            if (dec() != 0 || !ref_req || !init_done) bad++;
        end
        chk(bad == 0, "R6 quiet without grant", bad, 0);

        ref_gnt = 1'b1; tg = t; nref = 0;
        while (ref_req && t < tg + 200) begin
            step();
            if (dec() == 2) begin
                if (nref < 16) rt[nref] = t;
                nref++;
            end
        end
        chk(nref == CAP, "R7 backlog drain count", nref, CAP);
        chk(rt[0] == tg + 1, "R6 refresh after grant", rt[0] - tg, 1);
        chk(rt[1] - rt[0] == TRC, "R7 overdue pair spacing", rt[1] - rt[0], TRC);
        bad = 0;
        for (int i = 2; i < CAP; i++) if (rt[i] - rt[i-1] < TRC) bad++;
        chk(bad == 0, "R8 drain spacing", bad, 0);
        lastref = rt[CAP-1];

        // Random grant phase
        ref_gnt = 1'b0; ticks = 0; refs = 0; bad = 0;
        for (int k = 0; k < 3000; k++) begin
            step();
            if ((t - ti) % REFI == 0) ticks++;
            c = dec();
            if (c == 2) begin
                refs++;
                if (!ref_gnt) bad++;
                if (t - lastref < TRC) bad++;
                lastref = t;
            end else if (c != 0) bad++;
            if (!ref_req) ref_gnt = ($urandom % 4) == 0;
            else if (!ref_gnt) ref_gnt = ($urandom % 3) == 0;
        end
        ref_gnt = 1'b1;
        for (int k = 0; k < 300; k++) begin
            step();
            if ((t - ti) % REFI == 0) ticks++;
            c = dec();
            if (c == 2) begin
                refs++;
                if (t - lastref < TRC) bad++;
                lastref = t;
            end else if (c != 0) bad++;
            if (k > TRC + 2 && !ref_req) break;
        end
        chk(bad == 0, "R6 R8 random grant rules", bad, 0);
        chk(refs == ticks, "R5 refreshes equal credits", refs, ticks);

        // Self-refresh
        ref_gnt = 1'b0; tr = -1;
        for (int k = 0; k < REFI + 10 && tr < 0; k++) begin
            step();
            if (ref_req) tr = t;
        end
        chk(tr >= 0, "R5 ref_req before self-refresh", tr >= 0, 1);
        sr_req = 1'b1; ref_gnt = 1'b1;
        step();
        chk(dec() == 2 && !cke, "R9 self-refresh entry priority", {dec(), 4'(cke)}, 32);
        ref_gnt = 1'b0; bad = 0;
        for (int k = 0; k < 250; k++) begin
            step();
            if (cke || ref_req) bad++;
        end
        chk(bad == 0, "R10 cke held low", bad, 0);
        sr_req = 1'b0;
        step();
        chk(cke, "R10 cke rises", cke, 1);
        x = t; sr_req = 1'b1; ref_gnt = 1'b1; tc = -1; bad = 0;
        while (tc < 0 && t < x + 60) begin
            step();
            if (ref_req && t < x + TRC + 2) bad++;
            if (dec() != 0) tc = t;
        end
        chk(bad == 0, "R10 ref_req low during exit", bad, 0);
        chk(tc - x == TRC + 3, "R10 exit settle", tc - x, TRC + 3);
        chk(!cke, "R9 re-entry drops cke", cke, 0);
        ref_gnt = 1'b0;
        repeat (20) step();
        sr_req = 1'b0;
        step();
        x = t; tr = -1;
        chk(cke, "R10 second exit cke", cke, 1);
        while (tr < 0 && t < x + TRC + REFI + 20) begin
            step();
            if (ref_req) tr = t;
        end
        chk(tr - x == TRC + 2 + REFI, "R11 interval restart", tr - x, TRC + 2 + REFI);

        fin = 1;
        summary();
        $finish;
    end
endmodule